// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the general registers of a 32-bit processor core. The core reads and writes them by logical number, r0 to r15. A 5-bit mode input selects which physical copy each logical number reaches. Registers r0 to r7 and the program counter slot r15 are the same in every mode. The fast-interrupt mode swaps in its own r8 to r14. The four other exception modes swap in only their own stack pointer (r13) and link register (r14). The program counter sits in r15 as plain storage, and nothing here advances it.

The block also keeps one saved status word for each of the five exception modes. It offers a read port and a write port for the saved status word of the current mode. The unprivileged mode and the privileged mode that shares its registers have no saved status word. Two combinational read ports and one synchronous write port serve the general registers. A read that hits the register being written in the same cycle sees the new value. Decode, the ALU and exception sequencing sit outside this block.

Top module: `bnk_regfile`

## Requirements
- R1: After a synchronous active-high reset, every general register in every mode reads zero, and every saved status word reads zero.
- R2: Logical registers r0 to r7 and r15 are one physical set shared by all modes. A write in any mode is seen in every other mode.
- R3: In fast-interrupt mode (mode 5'b10001), r8 to r14 are private copies. Writes to them do not change the values that the user mode sees, and user-mode writes do not change them.
- R4: In interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes, r13 and r14 are private to each mode. In these modes r8 to r12 are the user copies.
- R5: System mode (5'b11111) uses exactly the user-mode (5'b10000) registers. Any mode code not listed in R3 to R5 behaves as user mode.
- R6: Each of the five exception modes has its own saved status word. A value written in one of these modes reads back only in that mode.
- R7: In user, system or unlisted modes, the saved status read port returns zero. A saved status write in these modes changes nothing.
- R8: General-register writes take effect at the rising clock edge when the write enable is high. The value then holds on both read ports until it is overwritten.
- R9: When a read port addresses the register that is being written in the same cycle and mode, that port returns the write data in that cycle.
- R10: When a saved status write is active in an exception mode, the saved status read port returns the write data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 5 | Current processor mode code |
| rd_a_addr | input | 4 | Logical register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 4 | Logical register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_addr | input | 4 | Logical register number to write |
| wr_data | input | 32 | General register write data |
| sts_wr_en | input | 1 | Saved status write enable for the current mode |
| sts_wr_data | input | 32 | Saved status write data |
| sts_rd_data | output | 32 | Saved status word of the current mode |

## Verification
A read and a write can hit the same physical register in the same cycle. The same is true of the saved status word. The bench provokes this by holding a write active while one read port addresses the written register and the other addresses an untouched neighbour. It checks before the edge that only the matching port shows the new data. After the edge it drops the enable and checks that the stored value holds. The same write-and-read collision is also applied in user mode to the saved status port, where the result must stay zero.

// File: rtl/bnk_pkg.sv
package bnk_pkg;

    localparam int DATA_W_DEF  = 32;
    localparam int MODE_W      = 5;
    localparam int LREG_N      = 16;
    localparam int LREG_W      = $clog2(LREG_N);
    localparam int SP_IDX      = 13;
    localparam int LR_IDX      = 14;
    localparam int FIQ_FIRST   = 8;
    localparam int FIQ_LAST    = 14;
    localparam int FIQ_N       = FIQ_LAST - FIQ_FIRST + 1;
    localparam int SHADOW_MODES = 4;
    localparam int SHADOW_BASE = LREG_N + FIQ_N;
    localparam int PHYS_N      = SHADOW_BASE + 2 * SHADOW_MODES;
    localparam int PHYS_W      = $clog2(PHYS_N);
    localparam int SAVED_N     = SHADOW_MODES + 1;
    localparam int RD_PORTS    = 2;

    typedef enum logic [MODE_W-1:0] {
        MD_USR = 5'b10000,
        MD_FIQ = 5'b10001,
        MD_IRQ = 5'b10010,
        MD_SVC = 5'b10011,
        MD_ABT = 5'b10111,
        MD_UND = 5'b11011,
        MD_SYS = 5'b11111
    } mode_e;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    typedef logic [PHYS_W-1:0] phys_idx_t;

    typedef struct packed {
        logic      en;
        phys_idx_t idx;
    } gpr_wr_t;

    function automatic bank_e mode_to_bank(logic [MODE_W-1:0] m);
        bank_e b;
        case (m)
            MD_FIQ:  b = BK_FIQ;
            MD_IRQ:  b = BK_IRQ;
            MD_SVC:  b = BK_SVC;
            MD_ABT:  b = BK_ABT;
            MD_UND:  b = BK_UND;
            default: b = BK_USR;
        endcase
        return b;
    endfunction

    function automatic phys_idx_t phys_index(bank_e b, logic [LREG_W-1:0] r);
        phys_idx_t res;
        int        slot;
        res  = PHYS_W'(r);
        slot = int'(b) - int'(BK_IRQ);
        if (b == BK_FIQ && int'(r) >= FIQ_FIRST && int'(r) <= FIQ_LAST) begin
            res = PHYS_W'(LREG_N + int'(r) - FIQ_FIRST);
        end else if (b != BK_USR && b != BK_FIQ &&
                     (int'(r) == SP_IDX || int'(r) == LR_IDX)) begin
            res = PHYS_W'(SHADOW_BASE + 2 * slot + ((int'(r) == LR_IDX) ? 1 : 0));
        end
        return res;
    endfunction

endpackage

// File: rtl/bnk_addr_map.sv
module bnk_addr_map
    import bnk_pkg::*;
(
    input  bank_e              bank,
    input  logic [LREG_W-1:0]  lreg,
    output phys_idx_t          pidx
);
    always_comb pidx = phys_index(bank, lreg);
endmodule

// File: rtl/bnk_gpr_array.sv
module bnk_gpr_array
    import bnk_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int NREGS  = PHYS_N,
    parameter int NRD    = RD_PORTS
) (
    input  logic              clk,
    input  logic              rst,
    input  gpr_wr_t           wr,
    input  logic [DATA_W-1:0] wr_data,
    input  phys_idx_t         rd_idx  [NRD],
    output logic [DATA_W-1:0] rd_data [NRD]
);
    logic [DATA_W-1:0] regs [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (wr.en && wr.idx == PHYS_W'(i)) begin
                regs[i] <= wr_data;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (wr.en && wr.idx == rd_idx[p]) begin
                rd_data[p] = wr_data;
            end else begin
                rd_data[p] = regs[rd_idx[p]];
            end
        end
    end
endmodule

// File: rtl/bnk_saved_sts.sv
module bnk_saved_sts
    import bnk_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int NSAVED = SAVED_N
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_e             bank,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SLOT_W = $clog2(NSAVED);

    logic [DATA_W-1:0] sts [NSAVED];
    logic              has_sts;
    logic [SLOT_W-1:0] slot;

    assign has_sts = (bank != BK_USR);
    assign slot    = SLOT_W'(int'(bank) - 1);

    for (genvar i = 0; i < NSAVED; i++) begin : g_sts
        always_ff @(posedge clk) begin
            if (rst) begin
                sts[i] <= '0;
            end else if (wr_en && has_sts && slot == SLOT_W'(i)) begin
                sts[i] <= wr_data;
            end
        end
    end

    always_comb begin
        if (!has_sts) begin
            rd_data = '0;
        end else if (wr_en) begin
            rd_data = wr_data;
        end else begin
            rd_data = sts[slot];
        end
    end
endmodule

// File: rtl/bnk_regfile.sv
module bnk_regfile
    import bnk_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        mode,
    input  logic [3:0]        rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sts_wr_en,
    input  logic [DATA_W-1:0] sts_wr_data,
    output logic [DATA_W-1:0] sts_rd_data
);
    localparam int NMAP = RD_PORTS + 1;

    bank_e             cur_bank;
    logic [LREG_W-1:0] lregs [NMAP];
    phys_idx_t         pidx  [NMAP];
    phys_idx_t         rd_idx  [RD_PORTS];
    logic [DATA_W-1:0] rd_vals [RD_PORTS];
    gpr_wr_t           wr_req;

    assign cur_bank = mode_to_bank(mode);
    assign lregs[0] = rd_a_addr;
    assign lregs[1] = rd_b_addr;
    assign lregs[2] = wr_addr;

    for (genvar k = 0; k < NMAP; k++) begin : g_map
        bnk_addr_map i_map (
            .bank (cur_bank),
            .lreg (lregs[k]),
            .pidx (pidx[k])
        );
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rdidx
        assign rd_idx[p] = pidx[p];
    end

    assign wr_req.en  = wr_en;
    assign wr_req.idx = pidx[RD_PORTS];

    bnk_gpr_array #(
        .DATA_W (DATA_W),
        .NREGS  (PHYS_N),
        .NRD    (RD_PORTS)
    ) i_gpr (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_req),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_vals)
    );

    assign rd_a_data = rd_vals[0];
    assign rd_b_data = rd_vals[1];

    bnk_saved_sts #(
        .DATA_W (DATA_W),
        .NSAVED (SAVED_N)
    ) i_sts (
        .clk     (clk),
        .rst     (rst),
        .bank    (cur_bank),
        .wr_en   (sts_wr_en),
        .wr_data (sts_wr_data),
        .rd_data (sts_rd_data)
    );
endmodule

// File: rtl/bnk_regfile_chk.sv
module bnk_regfile_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [4:0]        mode,
    input logic [3:0]        rd_a_addr,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [3:0]        rd_b_addr,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [3:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              sts_wr_en,
    input logic [DATA_W-1:0] sts_wr_data,
    input logic [DATA_W-1:0] sts_rd_data
);
    logic exc_mode;
    assign exc_mode = (mode == 5'b10001) || (mode == 5'b10010) || (mode == 5'b10011) ||
                      (mode == 5'b10111) || (mode == 5'b11011);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !wr_en) |-> (rd_a_data == '0 && rd_b_data == '0)); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && $stable(mode) && !wr_en && rd_a_addr == $past(wr_addr))
        |-> (rd_a_data == $past(wr_data))); // R8

    AST_BYPASS_A: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_a_addr == wr_addr) |-> (rd_a_data == wr_data)); // R9

    AST_BYPASS_B: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_b_addr == wr_addr) |-> (rd_b_data == wr_data)); // R9

    AST_STS_NONE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !exc_mode |-> (sts_rd_data == '0)); // R7

    AST_STS_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (sts_wr_en && exc_mode) |-> (sts_rd_data == sts_wr_data)); // R10
endmodule

bind bnk_regfile bnk_regfile_chk #(.DATA_W(DATA_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .rd_a_addr   (rd_a_addr),
    .rd_a_data   (rd_a_data),
    .rd_b_addr   (rd_b_addr),
    .rd_b_data   (rd_b_data),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .sts_wr_en   (sts_wr_en),
    .sts_wr_data (sts_wr_data),
    .sts_rd_data (sts_rd_data)
);

// File: tb/test_bnk_regfile.sv
module test_bnk_regfile;
    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  mode = M_USR;
    logic [3:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, sts_wr_data = '0, sts_rd_data;
    logic        wr_en = 1'b0, sts_wr_en = 1'b0;
    int          vectors = 0, fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    bnk_regfile i_bnk_regfile (
        .clk(clk), .rst(rst), .mode(mode),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .sts_rd_data(sts_rd_data)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] m, logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        mode = m; wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic swr(logic [4:0] m, logic [31:0] d);
        @(negedge clk);
        mode = m; sts_wr_data = d; sts_wr_en = 1'b1;
        @(negedge clk);
        sts_wr_en = 1'b0;
    endtask

    task automatic rd(string tag, logic [4:0] m, logic [3:0] a, logic [31:0] exp);
        @(negedge clk);
        mode = m; rd_a_addr = a; rd_b_addr = a;
        #2;
        check({tag, " port A"}, rd_a_data, exp);
        check({tag, " port B"}, rd_b_data, exp);
    endtask

    task automatic srd(string tag, logic [4:0] m, logic [31:0] exp);
        @(negedge clk);
        mode = m;
        #2;
        check(tag, sts_rd_data, exp);
    endtask

    task automatic t_reset;
        logic [4:0] ms [7] = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS};
        for (int k = 0; k < 7; k++) begin
            for (int r = 0; r < 16; r++) rd("R1 reset gpr", ms[k], 4'(r), 32'h0);
            srd("R1 reset saved status", ms[k], 32'h0);
        end
    endtask

    task automatic t_common;
        for (int r = 0; r < 8; r++) wr(M_USR, 4'(r), 32'hC000_0000 + r);
        wr(M_IRQ, 4'd15, 32'h0000_8000);
        for (int r = 0; r < 8; r++) begin
            rd("R2 common low in FIQ", M_FIQ, 4'(r), 32'hC000_0000 + r);
            rd("R2 common low in UND", M_UND, 4'(r), 32'hC000_0000 + r);
        end
        rd("R2 r15 common in USR", M_USR, 4'd15, 32'h0000_8000);
        rd("R2 r15 common in FIQ", M_FIQ, 4'd15, 32'h0000_8000);
        wr(M_FIQ, 4'd3, 32'h3333_F1F1);
        rd("R2 FIQ write to r3 seen in SVC", M_SVC, 4'd3, 32'h3333_F1F1);
    endtask

    task automatic t_fiq;
        for (int r = 8; r < 15; r++) wr(M_USR, 4'(r), 32'hA000_0000 + r);
        for (int r = 8; r < 15; r++) wr(M_FIQ, 4'(r), 32'hF000_0000 + r);
        for (int r = 8; r < 15; r++) begin
            rd("R3 FIQ private copy", M_FIQ, 4'(r), 32'hF000_0000 + r);
            rd("R3 user copy untouched", M_USR, 4'(r), 32'hA000_0000 + r);
        end
        for (int r = 8; r < 13; r++) rd("R4 IRQ shares user r8-r12", M_IRQ, 4'(r), 32'hA000_0000 + r);
    endtask

    task automatic t_shadow;
        logic [4:0] ms [4] = '{M_IRQ, M_SVC, M_ABT, M_UND};
        for (int k = 0; k < 4; k++) begin
            wr(ms[k], 4'd13, 32'h5B00_0000 + k);
            wr(ms[k], 4'd14, 32'h1E00_0000 + k);
        end
        for (int k = 0; k < 4; k++) begin
            rd("R4 private sp", ms[k], 4'd13, 32'h5B00_0000 + k);
            rd("R4 private lr", ms[k], 4'd14, 32'h1E00_0000 + k);
        end
        rd("R4 user sp untouched", M_USR, 4'd13, 32'hA000_000D);
        rd("R4 FIQ lr untouched", M_FIQ, 4'd14, 32'hF000_000E);
        wr(M_SVC, 4'd10, 32'h1010_5C5C);
        rd("R4 SVC write to r10 lands in user copy", M_USR, 4'd10, 32'h1010_5C5C);
    endtask

    task automatic t_system;
        wr(M_SYS, 4'd13, 32'h5150_0013);
        rd("R5 system sp is user sp", M_USR, 4'd13, 32'h5150_0013);
        rd("R5 system reads user r9", M_SYS, 4'd9, 32'hA000_0009);
        rd("R5 unlisted code 00000 as user", 5'b00000, 4'd13, 32'h5150_0013);
        wr(5'b10100, 4'd14, 32'h0B0B_0014);
        rd("R5 unlisted write lands in user lr", M_USR, 4'd14, 32'h0B0B_0014);
        rd("R5 IRQ lr untouched by unlisted", M_IRQ, 4'd14, 32'h1E00_0000);
    endtask

    task automatic t_sts;
        logic [4:0] ms [5] = '{M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND};
        for (int k = 0; k < 5; k++) swr(ms[k], 32'h5A5A_0000 + k);
        for (int k = 0; k < 5; k++) srd("R6 per-mode saved status", ms[k], 32'h5A5A_0000 + k);
    endtask

    task automatic t_sts_none;
        @(negedge clk);
        mode = M_USR; sts_wr_data = 32'hDEAD_0001; sts_wr_en = 1'b1;
        #2;
        check("R7 user saved status reads zero during write", sts_rd_data, 32'h0);
        @(negedge clk);
        sts_wr_en = 1'b0;
        srd("R7 user saved status zero after write", M_USR, 32'h0);
        swr(M_SYS, 32'hDEAD_0002);
        srd("R7 system saved status zero", M_SYS, 32'h0);
        srd("R7 FIQ saved status unchanged", M_FIQ, 32'h5A5A_0000);
        srd("R7 UND saved status unchanged", M_UND, 32'h5A5A_0004);
    endtask

    task automatic t_collide;
        @(negedge clk);
        mode = M_FIQ; rd_a_addr = 4'd8; rd_b_addr = 4'd9;
        wr_addr = 4'd8; wr_data = 32'hB7B7_0808; wr_en = 1'b1;
        #2;
        check("R9 port A bypass", rd_a_data, 32'hB7B7_0808);
        check("R9 port B unaffected neighbour", rd_b_data, 32'hF000_0009);
        @(negedge clk);
        wr_en = 1'b0;
        #2;
        check("R8 port A holds after edge", rd_a_data, 32'hB7B7_0808);
        rd_b_addr = 4'd8;
        #1;
        check("R8 port B sees stored value", rd_b_data, 32'hB7B7_0808);
        rd("R8 user r8 not hit by FIQ write", M_USR, 4'd8, 32'hA000_0008);
        @(negedge clk);
        mode = M_ABT; sts_wr_data = 32'h0AB0_0AB0; sts_wr_en = 1'b1;
        #2;
        check("R10 saved status bypass", sts_rd_data, 32'h0AB0_0AB0);
        @(negedge clk);
        sts_wr_en = 1'b0;
        #2;
        check("R10 saved status stored", sts_rd_data, 32'h0AB0_0AB0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_common();
        t_fiq();
        t_shadow();
        t_system();
        t_sts();
        t_sts_none();
        t_collide();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule